// File: doc/BRIEF.md
# Receiver Presence Probe Controller

This block is the digital control for one port of a multi-lane link repeater. It decides when the port's output drivers should probe for a receiver at the far end of the link. It selects the port's input termination, either high impedance or a 50 ohm load. It also sets the mode of the port's output channels: off, low-power idle or active. The impedance sensing itself is analog and sits outside this block. The block sees only one comparator flag per leg of the differential pair. A probe is counted as a hit only when every leg reports a valid load.

Three pins select the behaviour. An active-low presence input puts the port into power-down while it is high. A mode-select input chooses manual control (high) or automatic probing (low). A control input then picks the variant within that mode. In manual mode it selects idle/high-impedance or active/50 ohm. In automatic mode it selects either endless probing or probing inside a bounded window. The window restarts on a rising edge of the control input. All three pins pass through two-flop synchronisers. The probe period, the window length, the comparator sampling delay and the minimum power-down time are parameters counted in clock cycles. Their defaults correspond to 12 ms, 600 ms and 5 us at 100 MHz. The sampling delay must be shorter than the probe period minus one.

Top module: `rxdet_port_ctrl`

## Requirements
- R1: While the synchronised presence input is high, out_mode_o is 2'b00 (off) and term_50_o is 0, whatever the other pins are; no probe is launched.
- R2: With presence low and the mode-select input high, a low control input gives out_mode_o = 2'b01 (idle) and term_50_o = 0; no probe is launched.
- R3: With presence low and the mode-select input high, a high control input gives out_mode_o = 2'b10 (active) and term_50_o = 1.
- R4: In automatic mode with the control input low and no receiver found, det_strobe_o pulses high for exactly one cycle every PERIOD_CYC cycles, with no limit on the number of probes.
- R5: The comparator flags are read in the cycle SAMPLE_DLY cycles after the strobe cycle. A receiver is found only if all LEGS flags are 1 in that cycle. Any other pattern leaves term_50_o = 0 and out_mode_o = 2'b01, and probing continues.
- R6: In automatic mode, once a receiver is found, term_50_o becomes 1, out_mode_o becomes 2'b10 and no further probe is launched.
- R7: In automatic mode with the control input high, probes are launched only during the first WINDOW_CYC cycles after the window starts; afterwards det_strobe_o stays low and the port reports idle.
- R8: A rising edge of the synchronised control input in automatic mode restarts the window and launches a new probe sequence.
- R9: A probe launched before the window closes is still evaluated after it closes, and a hit from it counts as a detection.
- R10: A falling edge of presence after at least PD_MIN_CYC high cycles clears any earlier detection and window timeout, and probing starts again.
- R11: A presence high pulse shorter than PD_MIN_CYC cycles forces the port off while it lasts, but an earlier detection is kept afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prsnt_n_i | input | 1 | Active-low presence pin; high means power-down |
| man_en_i | input | 1 | Mode select: 1 manual, 0 automatic probing |
| det_ctl_i | input | 1 | Control pin: manual level or automatic variant / restart |
| leg_ok_i | input | LEGS | Per-leg comparator flags, 1 = valid load seen |
| det_strobe_o | output | 1 | One-cycle probe request to the analog driver |
| term_50_o | output | 1 | Input termination: 1 = 50 ohm, 0 = high impedance |
| out_mode_o | output | 2 | Output channel mode: 00 off, 01 idle, 10 active |

## Verification
The window timeout and the evaluation of a probe still in flight can land close together. With the bench parameters, the third probe of a window is launched 80 cycles into an 86-cycle window. Its comparator sample falls after the window has already closed. The bench waits for that third strobe, raises both leg flags only then, and expects the port to turn active, because the hit must count even though the timeout has fired. A second overlap is a restart edge on the control pin arriving while endless probing is under way. That case is provoked right after a strobe and is judged by the exact number of strobes in the new window.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

  typedef enum logic [1:0] {
    OM_OFF    = 2'b00,
    OM_IDLE   = 2'b01,
    OM_ACTIVE = 2'b10
  } out_mode_e;

  // Output channel mode from the synchronised pins and detection state.
  function automatic logic [1:0] mode_of(input logic pd, input logic man,
                                         input logic ctl, input logic det);
    if (pd)       return OM_OFF;
    else if (man) return ctl ? OM_ACTIVE : OM_IDLE;
    else          return det ? OM_ACTIVE : OM_IDLE;
  endfunction

  // Termination select: 1 selects the 50 ohm load.
  function automatic logic term_of(input logic pd, input logic man,
                                   input logic ctl, input logic det);
    if (pd)       return 1'b0;
    else if (man) return ctl;
    else          return det;
  endfunction

endpackage

// File: rtl/rxdet_sync.sv
module rxdet_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[i];
        stab <= RST_VAL[i];
      end else begin
        meta <= d_i[i];
        stab <= meta;
      end
    end
    assign q_o[i] = stab;
  end
endmodule

// File: rtl/rxdet_pwr.sv
module rxdet_pwr #(
  parameter int PD_MIN_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prsnt_n_s,
  output logic pd_active,
  output logic reinit
);
  localparam int CW = $clog2(PD_MIN_CYC + 1);
  localparam logic [CW-1:0] PD_FULL = CW'(PD_MIN_CYC);

  logic          prev_q;
  logic [CW-1:0] hi_cnt;

  assign pd_active = prsnt_n_s;
  // Re-arm only after a power-down that lasted the full minimum.
  assign reinit = prev_q & ~prsnt_n_s & (hi_cnt == PD_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      hi_cnt <= '0;
    end else begin
      prev_q <= prsnt_n_s;
      if (!prsnt_n_s)             hi_cnt <= '0;
      else if (hi_cnt != PD_FULL) hi_cnt <= hi_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rxdet_probe.sv
module rxdet_probe #(
  parameter int PERIOD_CYC = 1_200_000,
  parameter int WINDOW_CYC = 60_000_000,
  parameter int SAMPLE_DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic win_mode,
  input  logic restart,
  input  logic reinit,
  input  logic pair_ok,
  output logic strobe,
  output logic detected,
  output logic expired,
  output logic sample_ev
);
  localparam int TW = $clog2(PERIOD_CYC + 1);
  localparam int WW = $clog2(WINDOW_CYC + 1);
  localparam int SW = $clog2(SAMPLE_DLY + 2);
  localparam logic [TW-1:0] TMR_LOAD = TW'(PERIOD_CYC - 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW_CYC - 1);
  localparam logic [SW-1:0] SMP_LOAD = SW'(SAMPLE_DLY + 1);

  logic [TW-1:0] tmr;
  logic [WW-1:0] win;
  logic [SW-1:0] smp;
  logic          det_q, exp_q, stb_q;
  logic          run, fire, win_tick, win_last, hit;

  assign run       = auto_en & ~det_q & ~(win_mode & exp_q);
  assign fire      = run & (tmr == '0) & ~restart;
  assign win_tick  = auto_en & win_mode & ~det_q & ~exp_q;
  assign win_last  = win_tick & (win == WIN_LAST);
  assign sample_ev = auto_en & (smp == SW'(1));
  assign hit       = sample_ev & pair_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0; win <= '0; smp <= '0;
      det_q <= 1'b0; exp_q <= 1'b0; stb_q <= 1'b0;
    end else if (reinit) begin
      tmr <= '0; win <= '0; smp <= '0;
      det_q <= 1'b0; exp_q <= 1'b0; stb_q <= 1'b0;
    end else begin
      stb_q <= fire;
      if (restart) begin
        tmr   <= '0;
        win   <= '0;
        exp_q <= 1'b0;
      end else begin
        if (fire)                 tmr <= TMR_LOAD;
        else if (run && tmr != 0) tmr <= tmr - 1'b1;
        if (win_last)             exp_q <= 1'b1;
        else if (win_tick)        win <= win + 1'b1;
      end
      // In-flight samples survive window expiry but not a mode change.
      if (!auto_en)      smp <= '0;
      else if (fire)     smp <= SMP_LOAD;
      else if (smp != 0) smp <= smp - 1'b1;
      if (hit) det_q <= 1'b1;
    end
  end

  assign strobe   = stb_q;
  assign detected = det_q;
  assign expired  = exp_q;
endmodule

// File: rtl/rxdet_port_ctrl.sv
module rxdet_port_ctrl
  import rxdet_pkg::*;
#(
  parameter int PERIOD_CYC = 1_200_000,
  parameter int WINDOW_CYC = 60_000_000,
  parameter int SAMPLE_DLY = 16,
  parameter int PD_MIN_CYC = 500,
  parameter int LEGS       = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prsnt_n_i,
  input  logic            man_en_i,
  input  logic            det_ctl_i,
  input  logic [LEGS-1:0] leg_ok_i,
  output logic            det_strobe_o,
  output logic            term_50_o,
  output logic [1:0]      out_mode_o
);
  logic [2:0] pins_s;
  logic prsnt_s, man_s, ctl_s, ctl_d;
  logic pd_active, reinit, auto_en, ctl_rise, restart, pair_ok;
  logic detected, expired, sample_ev;

  rxdet_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({prsnt_n_i, man_en_i, det_ctl_i}),
    .q_o(pins_s)
  );
  assign {prsnt_s, man_s, ctl_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_d <= 1'b0;
    else        ctl_d <= ctl_s;
  end

  rxdet_pwr #(.PD_MIN_CYC(PD_MIN_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .prsnt_n_s(prsnt_s),
    .pd_active(pd_active), .reinit(reinit)
  );

  assign auto_en  = ~pd_active & ~man_s;
  assign ctl_rise = ctl_s & ~ctl_d;
  assign restart  = auto_en & ctl_rise;
  assign pair_ok  = &leg_ok_i;

  rxdet_probe #(
    .PERIOD_CYC(PERIOD_CYC), .WINDOW_CYC(WINDOW_CYC), .SAMPLE_DLY(SAMPLE_DLY)
  ) u_probe (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .win_mode(ctl_s),
    .restart(restart), .reinit(reinit), .pair_ok(pair_ok),
    .strobe(det_strobe_o), .detected(detected), .expired(expired),
    .sample_ev(sample_ev)
  );

  assign out_mode_o = mode_of(pd_active, man_s, ctl_s, detected);
  assign term_50_o  = term_of(pd_active, man_s, ctl_s, detected);
endmodule

// File: rtl/rxdet_port_ctrl_chk.sv
module rxdet_port_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pd_active,
  input logic       man_s,
  input logic       ctl_s,
  input logic       strobe,
  input logic       term,
  input logic [1:0] mode,
  input logic       detected,
  input logic       expired,
  input logic       sample_ev,
  input logic       pair_ok
);
  a_r1_pd_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> (mode == 2'b00) && !term);

  a_r1_pd_no_probe: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active && $past(pd_active) |-> !strobe);

  a_r2_manual_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_active && man_s && !ctl_s |-> (mode == 2'b01) && !term);

  a_r3_manual_active: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_active && man_s && ctl_s |-> (mode == 2'b10) && term);

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  a_r5_hit_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(detected) |-> $past(sample_ev && pair_ok));

  a_r6_quiet_when_found: assert property (@(posedge clk) disable iff (!rst_n)
    detected && $past(detected) |-> !strobe);

  a_r6_auto_found_active: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_active && !man_s && detected |-> term && (mode == 2'b10));

  a_r7_quiet_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    $past(expired && ctl_s) |-> !strobe);
endmodule

bind rxdet_port_ctrl rxdet_port_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pd_active(pd_active), .man_s(man_s),
  .ctl_s(ctl_s), .strobe(det_strobe_o), .term(term_50_o),
  .mode(out_mode_o), .detected(detected), .expired(expired),
  .sample_ev(sample_ev), .pair_ok(pair_ok)
);

// File: tb/tb_rxdet_port_ctrl.sv
module tb_rxdet_port_ctrl;
  localparam int PERIOD = 40;
  localparam int WINDOW = 86;
  localparam int DLY    = 8;
  localparam int PDMIN  = 20;
  localparam int LEGS   = 2;
  localparam int WIN_PROBES = (WINDOW + PERIOD - 1) / PERIOD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prsnt_n = 1'b1, man = 1'b0, ctl = 1'b0;
  logic [LEGS-1:0] legs = '0;
  logic strobe, term;
  logic [1:0] mode;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rxdet_port_ctrl #(
    .PERIOD_CYC(PERIOD), .WINDOW_CYC(WINDOW), .SAMPLE_DLY(DLY),
    .PD_MIN_CYC(PDMIN), .LEGS(LEGS)
  ) dut (
    .clk(clk), .rst_n(rst_n), .prsnt_n_i(prsnt_n), .man_en_i(man),
    .det_ctl_i(ctl), .leg_ok_i(legs), .det_strobe_o(strobe),
    .term_50_o(term), .out_mode_o(mode)
  );

  // Bench view of the expected mode: power-down wins, then manual level,
  // then the automatic detection result.
  function automatic int want_mode(bit pd, bit m, bit c, bit d);
    case ({pd, m})
      2'b10, 2'b11: return 0;
      2'b01:        return c ? 2 : 1;
      default:      return d ? 2 : 1;
    endcase
  endfunction

  function automatic bit want_hit(logic [LEGS-1:0] l);
    return l == {LEGS{1'b1}};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_strobes(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (strobe) c++;
    end
  endtask

  task automatic wait_strobe(output int waited);
    waited = -1;
    for (int i = 1; i <= 400; i++) begin
      @(negedge clk);
      if (strobe) begin
        waited = i;
        break;
      end
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all): actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    int c, w, s;
    bit det_m;
    s = $urandom(32'h5EED);
    tick(5);
    rst_n = 1'b1;
    tick(3);

    // R1: powered down after reset
    count_strobes(30, c);
    check("R1 strobes", c, 0);
    check("R1 mode", mode, 0);
    check("R1 term", term, 0);
    man = 1'b1; ctl = 1'b1; tick(5);
    check("R1 mode other pins", mode, 0);
    check("R1 term other pins", term, 0);

    // R2 / R3: manual levels
    prsnt_n = 1'b0; ctl = 1'b0; tick(5);
    check("R2 mode", mode, 1);
    check("R2 term", term, 0);
    count_strobes(100, c);
    check("R2 strobes", c, 0);
    ctl = 1'b1; tick(5);
    check("R3 mode", mode, 2);
    check("R3 term", term, 1);
    for (int k = 0; k < 10; k++) begin
      ctl = 1'($urandom % 2);
      tick(4);
      check(ctl ? "R3 random" : "R2 random", mode, want_mode(0, 1, ctl, 0));
      check(ctl ? "R3 random term" : "R2 random term", term, ctl);
    end

    // R4: endless probing
    ctl = 1'b0; man = 1'b0;
    wait_strobe(w);
    check("R4 first probe seen", w > 0, 1);
    @(negedge clk);
    check("R4 one-cycle strobe", strobe, 0);
    wait_strobe(w);
    check("R4 period", w + 1, PERIOD);

    // R5: partial leg patterns never detect
    for (int k = 0; k < 6; k++) begin
      wait_strobe(w);
      legs = ($urandom % 2) ? 2'b01 : 2'b10;
      if (k == 5) legs = 2'b00;
      tick(DLY + 2);
      check("R5 mode partial", mode, 1);
      check("R5 term partial", term, 0);
    end

    // R5 / R6: random patterns until a full pair
    det_m = 1'b0;
    for (int k = 0; k < 20 && !det_m; k++) begin
      wait_strobe(w);
      legs = LEGS'($urandom % 4);
      if (k == 19) legs = 2'b11;
      det_m = want_hit(legs);
      tick(DLY + 2);
      check("R5 random mode", mode, want_mode(0, 0, 0, det_m));
    end
    legs = 2'b00;
    check("R6 term", term, 1);
    count_strobes(3 * PERIOD, c);
    check("R6 no probes", c, 0);
    check("R6 mode", mode, 2);

    // R11: short power-down keeps detection
    prsnt_n = 1'b1; tick(4);
    check("R11 off during pulse", mode, 0);
    check("R11 term during pulse", term, 0);
    tick(1);
    prsnt_n = 1'b0; tick(6);
    check("R11 kept mode", mode, 2);
    check("R11 kept term", term, 1);

    // R10: full power-down clears detection
    prsnt_n = 1'b1;
    count_strobes(30, c);
    check("R1 no probe in power-down", c, 0);
    prsnt_n = 1'b0; tick(3);
    check("R10 cleared mode", mode, 1);
    check("R10 cleared term", term, 0);
    wait_strobe(w);
    check("R10 probing resumed", w > 0, 1);

    // R7: bounded window, entered right after a strobe
    ctl = 1'b1;
    count_strobes(300, c);
    check("R7 probes in window", c, WIN_PROBES);
    check("R7 idle after window", mode, 1);

    // R8: restart on rising control edge
    ctl = 1'b0; tick(4);
    ctl = 1'b1;
    count_strobes(300, c);
    check("R8 probes after restart", c, WIN_PROBES);

    // R10: full power-down clears the timeout as well
    prsnt_n = 1'b1; tick(30);
    prsnt_n = 1'b0;
    wait_strobe(w);
    check("R10 timeout cleared", w > 0 && w < 10, 1);

    // R9: last probe of the window, sampled after the window closes
    wait_strobe(w);
    wait_strobe(w);
    check("R9 third probe seen", w > 0, 1);
    legs = 2'b11;
    tick(DLY + 2);
    check("R9 late hit mode", mode, 2);
    check("R9 late hit term", term, 1);

    done = 1'b1;
    summary();
  end
endmodule